// File: doc/BRIEF.md
# Relay Output Safety Controller

This block sits between a 16-bit register interface and eight relay drivers. It keeps the relay pattern that software writes. It also keeps two switch-defined patterns: a startup pattern, loaded while reset is held, and an emergency pattern. An external emergency input or a watchdog overflow request makes the block take the emergency pattern, and the block keeps it until software writes an explicit recovery command.

The control register uses inverted polarity. A written 1 opens a relay's normally open contact and a written 0 closes it. The `relay_on` outputs and the readback use 1 = contact closed. While the emergency override is active, writes to the control register go only to a shadow copy. That copy drives the relays from the clock edge on which recovery is accepted.

The controller is a two-state machine. In MODE_RUN the relays follow the software pattern. In MODE_SAFE they follow the emergency switches. There are two transitions:
- T_TRIP (MODE_RUN to MODE_SAFE) is taken on a qualified emergency edge or a watchdog request while the enable bit is set.
- T_RECOVER (MODE_SAFE to MODE_RUN) is taken on a recovery write, unless a trip is requested in the same cycle.

Top module: `relay_safety_ctrl`

## Requirements
- R1: While `rst_n` is low, and after its release, `relay_on` equals `boot_sw`, the enable bit (offset 0x4, bit 0) reads 1, and the block is in MODE_RUN.
- R2: In MODE_RUN, a write to offset 0x0 makes `relay_on` equal to the inverse of `wr_data[7:0]` from the next clock edge on; `wr_data[15:8]` is ignored.
- R3: A read of offset 0x0 returns `relay_on` in bits 7:0 (1 = closed), and zeros in bits 15:8.
- R4: `emerg_in` passes through a two-flop synchronizer. With the enable bit set, a rising edge that is held high for at least two clocks puts the block in MODE_SAFE on the third clock edge after the input rises. In MODE_SAFE, `relay_on` follows `emerg_sw`.
- R5: In MODE_SAFE, writes to offset 0x0 leave `relay_on` unchanged. The last value written becomes the relay pattern once the block returns to MODE_RUN.
- R6: A write to offset 0x4 with bit 7 = 1 returns the block from MODE_SAFE to MODE_RUN on that clock edge. A write with bit 7 = 0 has no effect on the mode. A trip request in the same cycle takes priority, and the block stays in MODE_SAFE.
- R7: A one-cycle `wdog_ovf` pulse with the enable bit set puts the block in MODE_SAFE on that clock edge.
- R8: With the enable bit cleared (a write to offset 0x4 with bit 0 = 0), neither `emerg_in` nor `wdog_ovf` causes MODE_SAFE.
- R9: The read offsets are:
  - 0x4 returns the enable bit in bit 0.
  - 0x8 returns the mode in bit 3 (1 = MODE_SAFE).
  - 0xA returns `boot_sw` in bits 7:0.
  - 0xC returns `emerg_sw` in bits 7:0.
- R10: While `emerg_in` stays high, the block trips only once. After recovery it stays in MODE_RUN until the input falls and rises again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register byte offset for reads and writes |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Read data for `addr` (combinational) |
| boot_sw | input | 8 | Startup switch bank, 1 = closed |
| emerg_sw | input | 8 | Emergency switch bank, 1 = closed |
| emerg_in | input | 1 | Asynchronous emergency request |
| wdog_ovf | input | 1 | Watchdog overflow request, one-cycle pulse |
| relay_on | output | 8 | Relay drive, 1 = contact closed |

## Verification
The embedded properties check on every cycle that:
- a qualified trip always moves the machine to MODE_SAFE;
- a recovery without a concurrent trip always returns it to MODE_RUN;
- a disabled machine never leaves MODE_RUN;
- the synchronized edge detector never fires on two consecutive cycles;
- a write in MODE_RUN reaches the relays one edge later unless a trip intervenes.

Only the bench scenarios can show the rest:
- the three-edge latency of the emergency input;
- the shadow value taking effect after recovery;
- the single trip while the input stays high;
- trip-over-recovery priority when both arrive together;
- the readback of the switch banks.

// File: rtl/relay_safety_pkg.sv
`timescale 1ns/1ps
package relay_safety_pkg;
    typedef enum logic [0:0] {
        MODE_RUN  = 1'b0,
        MODE_SAFE = 1'b1
    } mode_e;

    localparam logic [3:0] OFS_RELAY  = 4'h0;
    localparam logic [3:0] OFS_SETUP  = 4'h4;
    localparam logic [3:0] OFS_STATUS = 4'h8;
    localparam logic [3:0] OFS_BOOT   = 4'hA;
    localparam logic [3:0] OFS_ESW    = 4'hC;

    localparam int EN_BIT      = 0;
    localparam int RECOVER_BIT = 7;
    localparam int SAFE_STAT   = 3;
endpackage

// File: rtl/emerg_sync.sv
`timescale 1ns/1ps
module emerg_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic rise_o
);
    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], async_i};
            prev_q <= sync_q[STAGES-1];
        end
    end

    assign rise_o = sync_q[STAGES-1] & ~prev_q;

    // R10: one trip per input edge
    a_r10_single_edge: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);
endmodule

// File: rtl/mode_fsm.sv
`timescale 1ns/1ps
module mode_fsm
    import relay_safety_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic trip_i,
    input  logic en_i,
    input  logic recover_i,
    output logic safe_o
);
    mode_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= MODE_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MODE_RUN:  if (trip_i && en_i) state_d = MODE_SAFE;            // T_TRIP
            MODE_SAFE: if (recover_i && !(trip_i && en_i)) state_d = MODE_RUN; // T_RECOVER
            default:   state_d = MODE_RUN;
        endcase
    end

    always_comb begin
        safe_o = (state_q == MODE_SAFE);
    end

    // R4 / R7: qualified trip always lands in MODE_SAFE
    a_r4_trip_enters: assert property (@(posedge clk) disable iff (!rst_n)
        (trip_i && en_i) |=> safe_o);
    // R6: recovery without trip returns to MODE_RUN
    a_r6_recover_exits: assert property (@(posedge clk) disable iff (!rst_n)
        (safe_o && recover_i && !trip_i) |=> !safe_o);
    // R8: disabled machine stays in MODE_RUN
    a_r8_disabled_stays: assert property (@(posedge clk) disable iff (!rst_n)
        (!safe_o && !en_i) |=> !safe_o);
endmodule

// File: rtl/ctrl_regs.sv
`timescale 1ns/1ps
module ctrl_regs
    import relay_safety_pkg::*;
#(
    parameter int CH = 8,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_relay_i,
    input  logic          wr_setup_i,
    input  logic [DW-1:0] wr_data_i,
    input  logic [CH-1:0] boot_sw_i,
    output logic [CH-1:0] ctrl_o,
    output logic          en_o,
    output logic          recover_o
);
    logic [CH-1:0] ctrl_q;
    logic          en_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= ~boot_sw_i;
            en_q   <= 1'b1;
        end else begin
            if (wr_relay_i) ctrl_q <= wr_data_i[CH-1:0];
            if (wr_setup_i) en_q   <= wr_data_i[EN_BIT];
        end
    end

    assign ctrl_o    = ctrl_q;
    assign en_o      = en_q;
    assign recover_o = wr_setup_i & wr_data_i[RECOVER_BIT];

    // R5: shadow only changes through a relay write
    a_r5_shadow_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_relay_i && $past(rst_n)) |=> $stable(ctrl_o));
endmodule

// File: rtl/relay_safety_ctrl.sv
`timescale 1ns/1ps
module relay_safety_ctrl
    import relay_safety_pkg::*;
#(
    parameter int CH          = 8,
    parameter int DW          = 16,
    parameter int AW          = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wr_data,
    output logic [DW-1:0] rd_data,
    input  logic [CH-1:0] boot_sw,
    input  logic [CH-1:0] emerg_sw,
    input  logic          emerg_in,
    input  logic          wdog_ovf,
    output logic [CH-1:0] relay_on
);
    localparam int PAD = DW - CH;

    logic          wr_relay, wr_setup;
    logic          emerg_rise, trip, en, recover, safe;
    logic [CH-1:0] ctrl;

    assign wr_relay = wr_en && (addr == OFS_RELAY);
    assign wr_setup = wr_en && (addr == OFS_SETUP);
    assign trip     = emerg_rise | wdog_ovf;

    emerg_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_i(emerg_in), .rise_o(emerg_rise)
    );

    ctrl_regs #(.CH(CH), .DW(DW)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_relay_i(wr_relay), .wr_setup_i(wr_setup),
        .wr_data_i(wr_data), .boot_sw_i(boot_sw), .ctrl_o(ctrl),
        .en_o(en), .recover_o(recover)
    );

    mode_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .trip_i(trip), .en_i(en),
        .recover_i(recover), .safe_o(safe)
    );

    for (genvar c = 0; c < CH; c++) begin : g_chan
        assign relay_on[c] = safe ? emerg_sw[c] : ~ctrl[c];
    end

    always_comb begin
        rd_data = '0;
        case (addr)
            OFS_RELAY:  rd_data = {{PAD{1'b0}}, relay_on};
            OFS_SETUP:  rd_data[EN_BIT] = en;
            OFS_STATUS: rd_data[SAFE_STAT] = safe;
            OFS_BOOT:   rd_data = {{PAD{1'b0}}, boot_sw};
            OFS_ESW:    rd_data = {{PAD{1'b0}}, emerg_sw};
            default:    rd_data = '0;
        endcase
    end

    // R2: a run-mode write reaches the relays one edge later unless a trip intervenes
    a_r2_write_applies: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_relay && !safe) |=> (safe || relay_on == ~$past(wr_data[CH-1:0])));
endmodule

// File: tb/relay_safety_ctrl_tb.sv
`timescale 1ns/1ps
module relay_safety_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  addr = 4'h0;
    logic [15:0] wr_data = 16'h0;
    logic [15:0] rd_data;
    logic [7:0]  boot_sw = 8'hA5;
    logic [7:0]  emerg_sw = 8'h3C;
    logic        emerg_in = 1'b0;
    logic        wdog_ovf = 1'b0;
    logic [7:0]  relay_on;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [7:0] m_ctrl;
    bit         m_safe;
    bit         m_en;

    always #2 clk = ~clk;

    relay_safety_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
        .rd_data(rd_data), .boot_sw(boot_sw), .emerg_sw(emerg_sw),
        .emerg_in(emerg_in), .wdog_ovf(wdog_ovf), .relay_on(relay_on)
    );

    function automatic logic [7:0] exp_relay();
        return m_safe ? emerg_sw : ~m_ctrl;
    endfunction

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        wr_en = 1'b1; addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] d);
        addr = a; #1; d = rd_data;
    endtask

    task automatic pulse_wdog();
        wdog_ovf = 1'b1;
        @(negedge clk);
        wdog_ovf = 1'b0;
    endtask

    initial begin
        logic [15:0] r;
        logic [31:0] d;
        d = $urandom(32'd4242);
        cyc(4);
        chk("R1 in reset", {8'h0, relay_on}, {8'h0, 8'hA5});
        rst_n = 1'b1;
        m_ctrl = ~8'hA5; m_safe = 0; m_en = 1;
        cyc(1);
        chk("R1 relay", {8'h0, relay_on}, 16'h00A5);
        rd(4'h4, r); chk("R1 enable", r, 16'h0001);
        rd(4'h8, r); chk("R1 status", r, 16'h0000);
        rd(4'hA, r); chk("R9 boot sw", r, 16'h00A5);
        rd(4'hC, r); chk("R9 emerg sw", r, 16'h003C);

        wr(4'h0, 16'hFF0F); m_ctrl = 8'h0F;
        chk("R2 write", {8'h0, relay_on}, {8'h0, exp_relay()});
        rd(4'h0, r); chk("R3 readback", r, 16'h00F0);

        for (int i = 0; i < 30; i++) begin
            d = $urandom;
            wr(4'h0, d[15:0]); m_ctrl = d[7:0];
            chk("R2 random write", {8'h0, relay_on}, {8'h0, ~d[7:0]});
            rd(4'h0, r); chk("R3 random readback", r, {8'h0, ~d[7:0]});
        end

        m_ctrl = 8'h00; wr(4'h0, 16'h0000);
        emerg_in = 1'b1; cyc(2); emerg_in = 1'b0;
        rd(4'h8, r); chk("R4 latency not yet", r, 16'h0000);
        chk("R4 relay unchanged", {8'h0, relay_on}, 16'h00FF);
        cyc(1); m_safe = 1;
        rd(4'h8, r); chk("R9 status safe", r, 16'h0008);
        chk("R4 emerg pattern", {8'h0, relay_on}, 16'h003C);

        wr(4'h0, 16'h0055); m_ctrl = 8'h55;
        chk("R5 write locked", {8'h0, relay_on}, 16'h003C);
        for (int i = 0; i < 5; i++) begin
            d = $urandom; emerg_sw = d[7:0]; #1;
            chk("R4 follows emerg sw", {8'h0, relay_on}, {8'h0, d[7:0]});
            rd(4'hC, r); chk("R9 emerg sw live", r, {8'h0, d[7:0]});
        end
        emerg_sw = 8'h3C;

        wr(4'h4, 16'h0001);
        rd(4'h8, r); chk("R6 bit7 zero no effect", r, 16'h0008);
        wr(4'h4, 16'h0081); m_safe = 0;
        rd(4'h8, r); chk("R6 recovered", r, 16'h0000);
        chk("R5 shadow applied", {8'h0, relay_on}, 16'h00AA);

        pulse_wdog(); m_safe = 1;
        chk("R7 watchdog trip", {8'h0, relay_on}, 16'h003C);
        wdog_ovf = 1'b1; wr(4'h4, 16'h0081); wdog_ovf = 1'b0;
        rd(4'h8, r); chk("R6 trip wins", r, 16'h0008);
        wr(4'h4, 16'h0081); m_safe = 0;
        chk("R6 recover after", {8'h0, relay_on}, 16'h00AA);

        wr(4'h4, 16'h0000); m_en = 0;
        rd(4'h4, r); chk("R9 enable cleared", r, 16'h0000);
        pulse_wdog();
        rd(4'h8, r); chk("R8 wdog ignored", r, 16'h0000);
        emerg_in = 1'b1; cyc(2); emerg_in = 1'b0; cyc(3);
        rd(4'h8, r); chk("R8 emerg ignored", r, 16'h0000);
        chk("R8 relay kept", {8'h0, relay_on}, 16'h00AA);
        wr(4'h4, 16'h0001); m_en = 1;

        emerg_in = 1'b1; cyc(4);
        rd(4'h8, r); chk("R10 first trip", r, 16'h0008);
        wr(4'h4, 16'h0081); cyc(5);
        rd(4'h8, r); chk("R10 no retrip while high", r, 16'h0000);
        emerg_in = 1'b0; cyc(3); emerg_in = 1'b1; cyc(4);
        rd(4'h8, r); chk("R10 retrip on new edge", r, 16'h0008);
        emerg_in = 1'b0; cyc(3);
        wr(4'h4, 16'h0081); m_safe = 0;

        for (int i = 0; i < 40; i++) begin
            d = $urandom;
            if (d[16]) begin pulse_wdog(); if (m_en) m_safe = 1; end
            if (d[18]) begin wr(4'h4, {8'h0, 7'h0, d[19]}); m_en = d[19]; end
            wr(4'h0, d[15:0]); m_ctrl = d[7:0];
            chk("R5 random mix", {8'h0, relay_on}, {8'h0, exp_relay()});
            if (d[17]) begin wr(4'h4, {8'h80, 7'h0, m_en} | 16'h0080); m_safe = 0; end
            chk("R6 random mix", {8'h0, relay_on}, {8'h0, exp_relay()});
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #800000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule